// File: doc/BRIEF.md
# Dual Timing Reference Selector

This block decides which of two timing references should discipline the system clock. Each reference has two health flags, an alarm and a frequency-offset-out-of-range flag. A reference counts as usable only after both flags have stayed low for a programmable number of clock ticks. A two-bit policy input sets how the block chooses between the two:
- it can stay locked to the preferred reference (index 0);
- it can fail over and then keep the backup;
- it can fail over and then return to the preferred reference once that reference has qualified again.

If neither reference is usable, the block raises a holdover flag and keeps the last selection. The downstream PLL then coasts. The PLL, the frequency measurement and the alarm detection all sit outside this block. Their results reach it as the flag inputs.

Top module: `refsel_top`

## Requirements
- R1: While reset is high and in the first cycle after it, ref_valid is 0, holdover is 1, sel_ref is 0 and sel_switch is 0.
- R2: ref_valid[i] rises on the (T+1)th consecutive rising edge that samples both ref_alarm[i] and ref_off_freq[i] low, where T = qual_time. Any edge that samples either flag high clears ref_valid[i] and restarts the count from zero.
- R3: ref_off_freq[i] high disqualifies reference i in the same way as ref_alarm[i]. ref_valid[i] is low after the first edge that samples it high.
- R4: holdover is high exactly when ref_valid was 0 in the previous cycle, in every policy. While holdover persists, sel_ref keeps its value, except that policy 0 forces it to 0.
- R5: With policy = 0 (locked), sel_ref is 0 in every cycle after reset, even while reference 0 is invalid.
- R6: With policy 1, 2 or 3, when the selected reference is invalid and the other one is valid, sel_ref changes to the other reference.
- R7: With policy 2 or 3 (revertive), sel_ref returns to 0 on the edge after ref_valid[0] is seen high.
- R8: With policy 1 (non-revertive), sel_ref stays on reference 1 after reference 0 qualifies again, as long as reference 1 stays valid.
- R9: On leaving holdover, sel_ref becomes 0 if ref_valid[0] was high, otherwise 1. holdover clears on that same edge.
- R10: sel_switch is high for exactly the one cycle in which sel_ref first shows a new value, and low otherwise.
- R11: sel_ref and holdover respond on the clock edge after the one at which ref_valid changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | 0 locked, 1 non-revertive, 2 or 3 revertive |
| qual_time | input | CNT_W | Qualification time T in clock ticks |
| ref_alarm | input | 2 | Alarm flag per reference |
| ref_off_freq | input | 2 | Frequency offset out of range flag per reference |
| ref_valid | output | 2 | Qualified status per reference |
| sel_ref | output | 1 | Index of the selected reference |
| holdover | output | 1 | Both references unusable |
| sel_switch | output | 1 | One-cycle pulse when sel_ref changes |

## Verification
ref_valid responds one edge after the flags: it is low one edge after a bad sample, and it rises T+1 edges after the first good one. sel_ref, holdover and sel_switch respond one further edge later. The bench drives inputs on the falling edge and samples on the next falling edge. Directed checks step through exact edge counts. A sweep over every policy and several values of qual_time compares each cycle against a bench model. The model tracks healthy streak lengths and applies the selection rules on the previous cycle's validity.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    POL_LOCKED  = 2'd0,
    POL_NONREV  = 2'd1,
    POL_REVERT  = 2'd2,
    POL_REVERT2 = 2'd3
  } pol_e;

  localparam int unsigned NREF  = 2;
  localparam int unsigned IDX_W = 1;
endpackage

// File: rtl/refsel_qualify.sv
module refsel_qualify #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alarm,
  input  logic             off_freq,
  input  logic [CNT_W-1:0] qual_time,
  output logic             valid_o
);
  logic [CNT_W-1:0] age_q;
  logic             valid_q;
  logic             ok;

  assign ok = !alarm && !off_freq;

  always_ff @(posedge clk) begin
    if (rst || !ok) begin
      age_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (age_q < qual_time) age_q <= age_q + 1'b1;
      valid_q <= (age_q >= qual_time);
    end
  end

  assign valid_o = valid_q;

  p_bad_clears_r2: assert property (@(posedge clk) disable iff (rst)
    alarm |=> (!valid_q && age_q == '0));
  p_offfreq_clears_r3: assert property (@(posedge clk) disable iff (rst)
    off_freq |=> !valid_q);
  p_rise_needs_health_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(ok));
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick
  import refsel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            policy,
  input  logic [NREF-1:0]       valid,
  output logic [IDX_W-1:0]      sel_o,
  output logic                  hold_o,
  output logic                  sw_o
);
  pol_e             pol;
  logic [IDX_W-1:0] sel_q, sel_n;
  logic             hold_q, hold_n, sw_q;

  assign pol = pol_e'(policy);

  always_comb begin
    sel_n  = sel_q;
    hold_n = (valid == '0);
    if (pol == POL_LOCKED) begin
      sel_n = '0;
    end else if (valid != '0) begin
      if (hold_q || pol == POL_REVERT || pol == POL_REVERT2)
        sel_n = valid[0] ? 1'b0 : 1'b1;
      else if (!valid[sel_q])
        sel_n = ~sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      hold_q <= 1'b1;
      sw_q   <= 1'b0;
    end else begin
      sel_q  <= sel_n;
      hold_q <= hold_n;
      sw_q   <= (sel_n != sel_q);
    end
  end

  assign sel_o  = sel_q;
  assign hold_o = hold_q;
  assign sw_o   = sw_q;

  p_hold_on_r4: assert property (@(posedge clk) disable iff (rst)
    (valid == '0) |=> hold_q);
  p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
    (valid != '0) |=> !hold_q);
  p_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd0) |=> (sel_q == '0));
  p_failover_r6: assert property (@(posedge clk) disable iff (rst)
    (policy != 2'd0 && !hold_q && !valid[sel_q] && valid[~sel_q])
    |=> (sel_q != $past(sel_q)));
  p_revert_r7: assert property (@(posedge clk) disable iff (rst)
    (policy[1] && valid[0]) |=> (sel_q == '0));
  p_nonrev_r8: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd1 && !hold_q && valid[sel_q]) |=> $stable(sel_q));
  p_switch_hi_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> sw_q);
  p_switch_lo_r10: assert property (@(posedge clk) disable iff (rst)
    $stable(sel_q) |-> !sw_q);
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policy,
  input  logic [CNT_W-1:0] qual_time,
  input  logic [1:0]       ref_alarm,
  input  logic [1:0]       ref_off_freq,
  output logic [1:0]       ref_valid,
  output logic             sel_ref,
  output logic             holdover,
  output logic             sel_switch
);
  logic [NREF-1:0] vld;

  for (genvar g = 0; g < NREF; g++) begin : g_qual
    refsel_qualify #(.CNT_W(CNT_W)) u_q (
      .clk       (clk),
      .rst       (rst),
      .alarm     (ref_alarm[g]),
      .off_freq  (ref_off_freq[g]),
      .qual_time (qual_time),
      .valid_o   (vld[g])
    );
  end

  refsel_pick u_pick (
    .clk    (clk),
    .rst    (rst),
    .policy (policy),
    .valid  (vld),
    .sel_o  (sel_ref),
    .hold_o (holdover),
    .sw_o   (sel_switch)
  );

  assign ref_valid = vld;
endmodule

// File: tb/sim_refsel_top.sv
module sim_refsel_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       policy = 2'd1;
  logic [CNT_W-1:0] qual_time = 16'd2;
  logic [1:0]       ref_alarm = 2'b11;
  logic [1:0]       ref_off_freq = 2'b00;
  logic [1:0]       ref_valid;
  logic             sel_ref, holdover, sel_switch;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refsel_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .policy(policy), .qual_time(qual_time),
    .ref_alarm(ref_alarm), .ref_off_freq(ref_off_freq),
    .ref_valid(ref_valid), .sel_ref(sel_ref), .holdover(holdover),
    .sel_switch(sel_switch)
  );

  // Bench model: healthy streak lengths, rules applied to last cycle's validity
  int   streak [2];
  logic [1:0] m_valid;
  logic m_sel, m_hold, m_sw;

  always @(posedge clk) begin
    logic [1:0] good;
    logic       nsel;
    good = ~(ref_alarm | ref_off_freq);
    if (rst) begin
      streak[0] <= 0; streak[1] <= 0;
      m_valid <= 2'b00; m_sel <= 1'b0; m_hold <= 1'b1; m_sw <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        int s;
        s = good[i] ? ((streak[i] < 1000) ? streak[i] + 1 : streak[i]) : 0;
        streak[i]  <= s;
        m_valid[i] <= (s >= int'(qual_time) + 1);
      end
      nsel = m_sel;
      if (policy == 2'd0) nsel = 1'b0;
      else if (m_valid == 2'b00) nsel = m_sel;
      else if (m_hold || policy >= 2'd2) nsel = m_valid[0] ? 1'b0 : 1'b1;
      else if (m_valid[m_sel] == 1'b0) nsel = ~m_sel;
      m_hold <= (m_valid == 2'b00);
      m_sw   <= (nsel != m_sel);
      m_sel  <= nsel;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (cmp_on) begin
        chk("R2 valid", ref_valid, m_valid);
        chk("R4 holdover", holdover, m_hold);
        chk("R6 sel", sel_ref, m_sel);
        chk("R10 switch", sel_switch, m_sw);
      end
    end
  endtask

  task automatic do_reset(input logic [1:0] pol, input int t);
    @(negedge clk);
    rst = 1'b1; policy = pol; qual_time = CNT_W'(t);
    step(2);
    rst = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    // Directed: non-revertive, T=2
    ref_alarm = 2'b11; ref_off_freq = 2'b00;
    do_reset(2'd1, 2);
    chk("R1 valid", ref_valid, 0);
    chk("R1 holdover", holdover, 1);
    chk("R1 sel", sel_ref, 0);
    chk("R1 switch", sel_switch, 0);
    ref_alarm = 2'b00;
    step(2);
    chk("R2 not yet valid", ref_valid, 0);
    step(1);
    chk("R2 valid after T+1", ref_valid, 3);
    chk("R11 holdover lags valid", holdover, 1);
    step(1);
    chk("R9 leave holdover", holdover, 0);
    chk("R9 pick ref0", sel_ref, 0);
    ref_off_freq = 2'b01;
    step(1);
    chk("R3 offfreq clears", ref_valid, 2);
    ref_off_freq = 2'b00;
    step(1);
    chk("R6 failover", sel_ref, 1);
    chk("R10 pulse", sel_switch, 1);
    step(1);
    chk("R10 pulse ends", sel_switch, 0);
    step(5);
    chk("R2 requalified", ref_valid, 3);
    chk("R8 stays on ref1", sel_ref, 1);

    // Directed: revertive, T=2
    ref_alarm = 2'b00;
    do_reset(2'd2, 2);
    step(4);
    chk("R9 sel", sel_ref, 0);
    ref_alarm = 2'b01;
    step(1);
    ref_alarm = 2'b00;
    step(1);
    chk("R6 failover rev", sel_ref, 1);
    step(1);
    ref_alarm = 2'b01;
    step(1);
    ref_alarm = 2'b00;
    step(2);
    chk("R2 restart after blip", ref_valid, 2);
    step(1);
    chk("R2 valid again", ref_valid, 3);
    chk("R11 sel lags", sel_ref, 1);
    step(1);
    chk("R7 reverts", sel_ref, 0);
    chk("R10 revert pulse", sel_switch, 1);
    ref_alarm = 2'b11;
    step(1);
    chk("R2 both cleared", ref_valid, 0);
    step(1);
    chk("R4 holdover", holdover, 1);
    chk("R4 sel kept", sel_ref, 0);
    ref_alarm = 2'b01;
    step(4);
    chk("R9 exit to ref1", sel_ref, 1);
    chk("R9 holdover clear", holdover, 0);
    chk("R10 exit pulse", sel_switch, 1);

    // Directed: locked with ref0 failed
    ref_alarm = 2'b01;
    do_reset(2'd0, 2);
    step(4);
    chk("R5 valid", ref_valid, 2);
    chk("R5 no holdover", holdover, 0);
    chk("R5 locked sel", sel_ref, 0);

    // Sweep: every policy, several qualification times, model compare
    lf = 16'hACE1;
    cmp_on = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int ti = 0; ti < 3; ti++) begin
        ref_alarm = 2'b00; ref_off_freq = 2'b00;
        do_reset(2'(p), ti * 3);
        for (int n = 0; n < 600; n++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (lf[3:0] == 4'd0) ref_alarm[0] = ~ref_alarm[0];
          if (lf[7:4] == 4'd0) ref_alarm[1] = ~ref_alarm[1];
          ref_off_freq[0] = (lf[11:8] == 4'd5);
          ref_off_freq[1] = (lf[15:12] == 4'd9);
          step(1);
        end
      end
    end
    cmp_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule